// File: doc/BRIEF.md
# Modified AMI line decoder

This block turns a received ternary line signal back into binary data. The signal arrives as two rail bits, positive and negative, with one symbol on every clock. Plain pulses that keep alternating in polarity become ones, and spaces become zeros. The block also finds the zero-substitution sequences that the far-end encoder put in place of long runs of zeros, and turns each one back into zeros.

A two-bit mode input picks one of four substitution codes. Each code has a fixed length: three, four, six or eight symbols. The mode is held steady while the block is out of reset, and it is changed only under reset. The decoded bit comes out with a valid strobe. A sticky error flag reports either of two faults: a symbol with both rails high, or a polarity violation that is not part of a legal substitution.

The block keeps an eight-entry history of classified symbols. When the last symbol of a legal sequence arrives, the block clears that sequence from the history. An entry reaches the output only after every sequence that could contain it has had the chance to complete.

Top module: `mami_decoder`

## Requirements
- R1: A single-rail pulse that alternates in polarity with the previous pulse decodes to 1, in any mode. A symbol with both rails low decodes to 0. Such input raises no error.
- R2: Four-zero mode (mode = 1) turns each of the following into four zeros: three spaces then a violation, or a clean pulse, two spaces, then a violation.
- R3: Three-zero mode (mode = 0) turns each of the following into three zeros: two spaces then a violation, or a clean pulse, one space, then a violation.
- R4: Six-zero mode (mode = 2) turns the sequence space, violation, clean pulse, space, violation, clean pulse into six zeros.
- R5: Eight-zero mode (mode = 3) turns the sequence three spaces, violation, clean pulse, space, violation, clean pulse into eight zeros.
- R6: In modes 0 and 1, a violation with the same polarity as the previous violation is not accepted as a substitution. It sets the error flag, decodes to 1, and the spaces before it still decode to 0. A violation is a pulse with the same polarity as the pulse just before it. The first violation after reset is always accepted.
- R7: A symbol with both rails high sets the error flag, decodes to 1, and does not change the polarity reference for the pulses that follow.
- R8: A violation that does not complete a legal sequence for the selected mode sets the error flag and decodes to 1. The flag stays set until reset.
- R9: Let L be the sequence length of the mode (3, 4, 6 or 8). A symbol sampled at rising edge k appears on dout after edge k+L+1. After reset is released, the first symbol is sampled on the first rising edge, so dout_vld first rises after edge L+2. It then stays high.
- R10: Reset clears dout_vld, err and all history, so an error from before reset does not carry over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Code select: 0 three-zero, 1 four-zero, 2 six-zero, 3 eight-zero |
| rail_p | input | 1 | Positive-pulse rail |
| rail_n | input | 1 | Negative-pulse rail |
| dout | output | 1 | Decoded data bit |
| dout_vld | output | 1 | Decoded bit is valid |
| err | output | 1 | Sticky error flag for a violation or an illegal symbol |

## Verification
The properties assume that the mode stays fixed while reset is released, and that a new symbol is presented on every clock with no gaps. Only under those conditions does the valid strobe, once high, stay high. The stimulus meets both assumptions. Every scenario changes the mode only while reset is held low, and the rails are driven on every cycle. After each pattern the bench drives trailing spaces, so the pipeline drains without starting a new substitution.

// File: rtl/mami_decoder.sv
module mami_decoder #(
  parameter int DEPTH = 8,
  parameter int CNTW  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       rail_p,
  input  logic       rail_n,
  output logic       dout,
  output logic       dout_vld,
  output logic       err
);
  localparam int IW = $clog2(DEPTH);

  logic             r_p, r_n;
  logic [DEPTH-1:0] bp, bv, bx;
  logic             last_neg, seen, last_vneg, vseen;
  logic [CNTW-1:0]  cnt, len;
  logic [IW-1:0]    tap;
  logic [DEPTH-1:0] clr;

  wire in_x     = r_p & r_n;
  wire in_pulse = r_p ^ r_n;
  wire in_v     = in_pulse & seen & (r_n == last_neg);
  wire in_b     = in_pulse & ~in_v;
  wire valt     = ~vseen | (r_n != last_vneg);

  wire [DEPTH-1:0] zr = ~bp & ~bx;
  wire [DEPTH-1:0] cl = bp & ~bv & ~bx;

  wire m3 = (mode == 2'd0) & in_v & valt & zr[0] & (zr[1] | cl[1]);
  wire m4 = (mode == 2'd1) & in_v & valt & zr[0] & zr[1] & (zr[2] | cl[2]);
  wire m6 = (mode == 2'd2) & in_b & bv[0] & zr[1] & cl[2] & bv[3] & zr[4];
  wire m8 = (mode == 2'd3) & in_b & bv[0] & zr[1] & cl[2] & bv[3]
            & zr[4] & zr[5] & zr[6];
  wire hit = m3 | m4 | m6 | m8;

  always_comb begin
    case (mode)
      2'd0:    len = CNTW'(3);
      2'd1:    len = CNTW'(4);
      2'd2:    len = CNTW'(6);
      default: len = CNTW'(8);
    endcase
    tap = IW'(len - CNTW'(1));
  end

  always_comb begin
    clr = '0;
    if (m3) clr[1:0] = '1;
    if (m4) clr[2:0] = '1;
    if (m6) clr[4:0] = '1;
    if (m8) clr[6:0] = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_p       <= 1'b0;
      r_n       <= 1'b0;
      bp        <= '0;
      bv        <= '0;
      bx        <= '0;
      last_neg  <= 1'b0;
      seen      <= 1'b0;
      last_vneg <= 1'b0;
      vseen     <= 1'b0;
      cnt       <= '0;
      dout      <= 1'b0;
      dout_vld  <= 1'b0;
      err       <= 1'b0;
    end else begin
      r_p <= rail_p;
      r_n <= rail_n;
      bp  <= {bp[DEPTH-2:0] & ~clr[DEPTH-2:0], in_pulse & ~hit};
      bv  <= {bv[DEPTH-2:0] & ~clr[DEPTH-2:0], in_v & ~hit};
      bx  <= {bx[DEPTH-2:0], in_x};
      if (in_pulse) begin
        last_neg <= r_n;
        seen     <= 1'b1;
      end
      if (in_v) begin
        last_vneg <= r_n;
        vseen     <= 1'b1;
      end
      if (cnt != '1) cnt <= cnt + CNTW'(1);
      dout     <= bp[tap] | bx[tap];
      dout_vld <= cnt > len;
      err      <= err | in_x | bv[tap];
    end
  end
endmodule

// File: rtl/mami_decoder_chk.sv
module mami_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rail_p,
  input logic       rail_n,
  input logic       dout_vld,
  input logic       err
);
  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!err && !dout_vld)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err |=> err); // R8
  AST_BOTH_RAILS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (rail_p && rail_n) |=> ##1 err); // R7
  AST_VLD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) dout_vld |=> dout_vld); // R9
endmodule

bind mami_decoder mami_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rail_p(rail_p), .rail_n(rail_n),
  .dout_vld(dout_vld), .err(err)
);

// File: tb/mami_decoder_tb.sv
`timescale 1ns/1ps
module mami_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic rail_p = 1'b0, rail_n = 1'b0;
  logic dout, dout_vld, err;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mami_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rail_p(rail_p), .rail_n(rail_n),
    .dout(dout), .dout_vld(dout_vld), .err(err)
  );

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic run_case(string req, logic [1:0] m, string syms, string exp, bit exp_err);
    int L, first, nout;
    int act_v, exp_v;
    L = (m == 2'd0) ? 3 : (m == 2'd1) ? 4 : (m == 2'd2) ? 6 : 8;
    @(negedge clk);
    rst_n = 1'b0; mode = m; rail_p = 1'b1; rail_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!dout_vld && !err, "R10", "reset state", {dout_vld, err}, 0);
    first = -1; nout = 0; act_v = 0; exp_v = 0;
    for (int i = 0; i < exp.len(); i++) exp_v = (exp_v << 1) | (exp[i] == "1" ? 1 : 0);
    for (int c = 0; c < syms.len() + L + 4; c++) begin
      if (c > 0 && dout_vld) begin
        if (first < 0) first = c;
        if (nout < exp.len()) begin
          act_v = (act_v << 1) | int'(dout);
          nout++;
        end
      end
      rail_p = 1'b0; rail_n = 1'b0;
      if (c < syms.len()) begin
        if (syms[c] == "+") rail_p = 1'b1;
        else if (syms[c] == "-") rail_n = 1'b1;
        else if (syms[c] == "X") begin rail_p = 1'b1; rail_n = 1'b1; end
      end
      if (c == 0) rst_n = 1'b1;
      @(negedge clk);
    end
    chk(first == L + 2, "R9", "first valid cycle", first, L + 2);
    chk(nout == exp.len() && act_v == exp_v, req, "decoded bits", act_v, exp_v);
    chk(err == exp_err, req, "error flag", int'(err), int'(exp_err));
  endtask

  task automatic t_ami();       run_case("R1", 2'd1, "+0-+00-", "1011001", 1'b0); endtask
  task automatic t_ami8();      run_case("R1", 2'd3, "-+0-", "1101", 1'b0); endtask
  task automatic t_four_zero(); run_case("R2", 2'd1, "+000+-000-", "1000010000", 1'b0); endtask
  task automatic t_four_b();    run_case("R2", 2'd1, "+000+-00-", "100000000", 1'b0); endtask
  task automatic t_three();     run_case("R3", 2'd0, "+00+-0-+", "10000001", 1'b0); endtask
  task automatic t_six();       run_case("R4", 2'd2, "+0+-0-+-", "10000001", 1'b0); endtask
  task automatic t_eight();     run_case("R5", 2'd3, "-000-+0+-+", "1000000001", 1'b0); endtask
  task automatic t_valt();      run_case("R6", 2'd1, "+000+-+000+", "10000110001", 1'b1); endtask
  task automatic t_both();      run_case("R7", 2'd1, "+X-", "111", 1'b1); endtask
  task automatic t_stray();     run_case("R8", 2'd3, "+0+-00", "101100", 1'b1); endtask
  task automatic t_after_err(); run_case("R10", 2'd0, "+0-", "101", 1'b0); endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_ami();
    t_ami8();
    t_four_zero();
    t_four_b();
    t_three();
    t_six();
    t_eight();
    t_valt();
    t_both();
    t_after_err();
    t_stray();
    t_after_err();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule